// File: doc/BRIEF.md
# NAND Register Access Serializer

This block sits behind the register port of an external memory controller and turns a single host register access into the sequence of NAND flash I/O cycles that access implies. Each chip select owns a register window holding a command register, an address register and a data register. A write to the command register sends its bytes with the command latch enable raised. A write to the address register sends them with the address latch enable raised. An access to the data register moves data with neither latch enable raised.

The host presents an access of 1, 2 or 4 bytes. The access is held on a valid/ready handshake until the last NAND cycle has finished. The block looks up the device type and the bus width of the addressed chip select in that chip select's configuration word. On an 8-bit device it splits the access into bytes. On a 16-bit device it splits it into halfwords, lowest-order part first. Reads are assembled little-endian from the successive cycles and returned with the completion. Accesses to any other register produce no NAND traffic, but the block still completes them and reports a width error when the access is narrower than a word.

Top module: `nand_reg_serializer`

## Requirements
- R1: A chip select counts as a NAND device only when bits [11:10] of its configuration word equal 2. On any other type, command, address and data register accesses run no NAND cycle, complete without error and read back 0. Reads of the command or address register also run no cycle and return 0.
- R2: Bit 12 of the configuration word selects the bus width (0 = 8-bit, 1 = 16-bit). Bit 13 has no effect.
- R3: Window i starts at byte address 0x60 + 0x30*i, for i = 0..7. The command register sits at window offset 0x1C, the address register at 0x20 and the data register at 0x24, and each answers on all four of its byte addresses. During the cycles only the chip enable of the addressed chip select is low.
- R4: Command writes raise only CLE, address writes raise only ALE, and data accesses raise neither. The qualifier stays stable across each strobe and the idle clock after it.
- R5: On an 8-bit device, sizes 1, 2 and 4 bytes (req_size_i = 0, 1, 2) take 1, 2 and 4 cycles. Cycle k carries byte k of the value on dq[7:0], with dq[15:8] driven to 0. Read bytes land at byte k of the response.
- R6: On a 16-bit device, a 2-byte access takes one cycle and a 4-byte access takes two cycles, carrying halfword k in cycle k for both writes and reads.
- R7: A 1-byte read from a 16-bit device runs one cycle and returns only dq[7:0], with the upper response bits 0. A 1-byte write to a 16-bit device runs one cycle carrying req_wdata_i[15:0].
- R8: An address outside the three NAND registers runs no NAND cycle and reads back 0. It completes with rsp_err_o high exactly when req_size_i[1] is 0 (narrower than a word). req_size_i = 3 counts as a word on every register.
- R9: Each cycle is a one-clock low pulse of nand_we_no (write) or nand_re_no (read), followed by one idle clock. nand_dq_oe_o is high during write strobes, and read data is sampled at the end of the read strobe.
- R10: After the handshake edge that accepts a request with N NAND cycles, req_ready_o and rsp_valid_o go high together for exactly one clock, 2N+1 clocks later. rsp_rdata_o and rsp_err_o are valid in that clock.
- R11: In reset and when idle, all chip enables, nand_we_no and nand_re_no are high, CLE and ALE are low, and req_ready_o and rsp_valid_o are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Host request valid, held until req_ready_o |
| req_ready_o | output | 1 | Request completed and accepted |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W (12) | Byte address within the controller register space |
| req_size_i | input | 2 | 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes |
| req_wdata_i | input | 32 | Write value, low-order bytes significant |
| cs_cfg_i | input | CS_N*16 (128) | Low half of each chip select's configuration word, chip select i at [16i+15:16i] |
| rsp_valid_o | output | 1 | Response pulse |
| rsp_rdata_o | output | 32 | Assembled read data |
| rsp_err_o | output | 1 | Bad-width access to a word-only register |
| nand_ce_no | output | CS_N (8) | Active-low chip enables |
| nand_cle_o | output | 1 | Command latch enable |
| nand_ale_o | output | 1 | Address latch enable |
| nand_we_no | output | 1 | Active-low write strobe |
| nand_re_no | output | 1 | Active-low read strobe |
| nand_dq_o | output | 16 | NAND output data |
| nand_dq_oe_o | output | 1 | NAND output data enable |
| nand_dq_i | input | 16 | NAND input data |

## Verification
The checks on the response assume that the host holds req_valid_i, the address, size, write flag and data unchanged from request until completion. One property states this assumption, and the response-error check depends on it. The checks also assume that cs_cfg_i does not change while a request is open. The stimulus changes configuration and request fields only at a falling edge while the block is idle. It raises valid at a falling edge and drops it one falling edge after completion is seen. It drives the NAND input bus at the falling edge inside each read strobe, so the sampled value is settled at the end of the strobe.

// File: rtl/nrs_pkg.sv
package nrs_pkg;
  localparam int HOST_W = 32;
  localparam int DQ_W   = 16;
  localparam int CFG_W  = 16;
  localparam logic [1:0] DEV_NAND = 2'd2;

  typedef enum logic [1:0] {
    KIND_CMD  = 2'd0,
    KIND_ADR  = 2'd1,
    KIND_DAT  = 2'd2,
    KIND_NONE = 2'd3
  } reg_kind_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_STRB = 2'd1,
    ST_GAP  = 2'd2,
    ST_DONE = 2'd3
  } seq_st_e;
endpackage

// File: rtl/nrs_decode.sv
module nrs_decode
  import nrs_pkg::*;
#(
  parameter int CS_N       = 8,
  parameter int ADDR_W     = 12,
  parameter int WIN_BASE   = 'h60,
  parameter int WIN_STRIDE = 'h30,
  parameter int CMD_OFF    = 'h1C,
  parameter int ADR_OFF    = 'h20,
  parameter int DAT_OFF    = 'h24
) (
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CS_N*CFG_W-1:0] cs_cfg_i,
  output reg_kind_e             kind_o,
  output logic [CS_N-1:0]       cs_sel_o,
  output logic                  is_nand_o,
  output logic                  wide_o
);
  logic [CS_N-1:0] hit_cmd, hit_adr, hit_dat;
  logic [CFG_W-1:0] cfg_sel;

  // one comparator set per window: word address match, any byte lane
  for (genvar i = 0; i < CS_N; i++) begin : g_win
    localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(WIN_BASE + i*WIN_STRIDE + CMD_OFF);
    localparam logic [ADDR_W-1:0] ADR_A = ADDR_W'(WIN_BASE + i*WIN_STRIDE + ADR_OFF);
    localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(WIN_BASE + i*WIN_STRIDE + DAT_OFF);
    assign hit_cmd[i] = addr_i[ADDR_W-1:2] == CMD_A[ADDR_W-1:2];
    assign hit_adr[i] = addr_i[ADDR_W-1:2] == ADR_A[ADDR_W-1:2];
    assign hit_dat[i] = addr_i[ADDR_W-1:2] == DAT_A[ADDR_W-1:2];
  end

  assign cs_sel_o = hit_cmd | hit_adr | hit_dat;

  always_comb begin
    if (|hit_cmd)      kind_o = KIND_CMD;
    else if (|hit_adr) kind_o = KIND_ADR;
    else if (|hit_dat) kind_o = KIND_DAT;
    else               kind_o = KIND_NONE;
  end

  always_comb begin
    cfg_sel = '0;
    for (int i = 0; i < CS_N; i++)
      if (cs_sel_o[i]) cfg_sel = cs_cfg_i[i*CFG_W +: CFG_W];
  end

  assign is_nand_o = cfg_sel[11:10] == DEV_NAND;
  assign wide_o    = cfg_sel[12];    // bit 13 deliberately ignored

  logic unused_bits;
  assign unused_bits = ^{addr_i[1:0], cfg_sel[CFG_W-1:13], cfg_sel[9:0]};
endmodule

// File: rtl/nrs_plan.sv
module nrs_plan
  import nrs_pkg::*;
(
  input  reg_kind_e   kind_i,
  input  logic        is_nand_i,
  input  logic        wide_i,
  input  logic        write_i,
  input  logic [1:0]  size_i,
  output logic [2:0]  ncyc_o,
  output logic        err_o
);
  logic       run;
  logic [2:0] raw;

  // data register moves both ways; command/address registers are write-only
  assign run = is_nand_i && (kind_i != KIND_NONE) && (kind_i == KIND_DAT || write_i);

  always_comb begin
    if (!wide_i) raw = size_i[1] ? 3'd4 : (size_i[0] ? 3'd2 : 3'd1);
    else         raw = size_i[1] ? 3'd2 : 3'd1;
  end

  assign ncyc_o = run ? raw : 3'd0;
  assign err_o  = (kind_i == KIND_NONE) && !size_i[1];
endmodule

// File: rtl/nrs_seq.sv
module nrs_seq
  import nrs_pkg::*;
#(
  parameter int CS_N = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic              write_i,
  input  logic [1:0]        size_i,
  input  logic [HOST_W-1:0] wdata_i,
  input  reg_kind_e         kind_i,
  input  logic [CS_N-1:0]   cs_sel_i,
  input  logic              wide_i,
  input  logic [2:0]        ncyc_i,
  input  logic              err_i,
  output logic              done_o,
  output logic [HOST_W-1:0] rdata_o,
  output logic              err_o,
  output logic [CS_N-1:0]   ce_no,
  output logic              cle_o,
  output logic              ale_o,
  output logic              we_no,
  output logic              re_no,
  output logic [DQ_W-1:0]   dq_o,
  output logic              dq_oe_o,
  input  logic [DQ_W-1:0]   dq_i
);
  seq_st_e           st_q;
  logic              wr_q, wide_q, err_q;
  logic [1:0]        size_q, idx_q;
  logic [2:0]        ncyc_q;
  logic [HOST_W-1:0] wdata_q, rdata_q;
  logic [CS_N-1:0]   cs_q;
  reg_kind_e         kind_q;
  logic              active;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      wr_q    <= 1'b0;
      wide_q  <= 1'b0;
      err_q   <= 1'b0;
      size_q  <= '0;
      idx_q   <= '0;
      ncyc_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      cs_q    <= '0;
      kind_q  <= KIND_NONE;
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          wr_q    <= write_i;
          wide_q  <= wide_i;
          err_q   <= err_i;
          size_q  <= size_i;
          idx_q   <= '0;
          ncyc_q  <= ncyc_i;
          wdata_q <= wdata_i;
          rdata_q <= '0;
          cs_q    <= cs_sel_i;
          kind_q  <= kind_i;
          st_q    <= (ncyc_i != 3'd0) ? ST_STRB : ST_DONE;
        end
        ST_STRB: begin
          if (!wr_q) begin
            if (!wide_q)              rdata_q[{idx_q, 3'b000} +: 8]     <= dq_i[7:0];
            else if (size_q == 2'd0)  rdata_q[7:0]                      <= dq_i[7:0];
            else                      rdata_q[{idx_q[0], 4'b0000} +: 16] <= dq_i;
          end
          st_q <= ST_GAP;
        end
        ST_GAP: begin
          idx_q <= idx_q + 2'd1;
          st_q  <= ({1'b0, idx_q} + 3'd1 == ncyc_q) ? ST_DONE : ST_STRB;
        end
        ST_DONE: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign active  = (st_q == ST_STRB) || (st_q == ST_GAP);
  assign ce_no   = active ? ~cs_q : '1;
  assign cle_o   = active && (kind_q == KIND_CMD);
  assign ale_o   = active && (kind_q == KIND_ADR);
  assign we_no   = !((st_q == ST_STRB) && wr_q);
  assign re_no   = !((st_q == ST_STRB) && !wr_q);
  assign dq_oe_o = active && wr_q;
  assign dq_o    = wide_q ? wdata_q[{idx_q[0], 4'b0000} +: 16]
                          : {8'h00, wdata_q[{idx_q, 3'b000} +: 8]};
  assign done_o  = st_q == ST_DONE;
  assign rdata_o = rdata_q;
  assign err_o   = err_q;
endmodule

// File: rtl/nand_reg_serializer.sv
module nand_reg_serializer
  import nrs_pkg::*;
#(
  parameter int CS_N   = 8,
  parameter int ADDR_W = 12
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  output logic                  req_ready_o,
  input  logic                  req_write_i,
  input  logic [ADDR_W-1:0]     req_addr_i,
  input  logic [1:0]            req_size_i,
  input  logic [31:0]           req_wdata_i,
  input  logic [CS_N*16-1:0]    cs_cfg_i,
  output logic                  rsp_valid_o,
  output logic [31:0]           rsp_rdata_o,
  output logic                  rsp_err_o,
  output logic [CS_N-1:0]       nand_ce_no,
  output logic                  nand_cle_o,
  output logic                  nand_ale_o,
  output logic                  nand_we_no,
  output logic                  nand_re_no,
  output logic [15:0]           nand_dq_o,
  output logic                  nand_dq_oe_o,
  input  logic [15:0]           nand_dq_i
);
  reg_kind_e       kind;
  logic [CS_N-1:0] cs_sel;
  logic            is_nand, wide, plan_err, done;
  logic [2:0]      ncyc;

  nrs_decode #(.CS_N(CS_N), .ADDR_W(ADDR_W)) u_dec (
    .addr_i    (req_addr_i),
    .cs_cfg_i  (cs_cfg_i),
    .kind_o    (kind),
    .cs_sel_o  (cs_sel),
    .is_nand_o (is_nand),
    .wide_o    (wide)
  );

  nrs_plan u_plan (
    .kind_i    (kind),
    .is_nand_i (is_nand),
    .wide_i    (wide),
    .write_i   (req_write_i),
    .size_i    (req_size_i),
    .ncyc_o    (ncyc),
    .err_o     (plan_err)
  );

  nrs_seq #(.CS_N(CS_N)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .write_i     (req_write_i),
    .size_i      (req_size_i),
    .wdata_i     (req_wdata_i),
    .kind_i      (kind),
    .cs_sel_i    (cs_sel),
    .wide_i      (wide),
    .ncyc_i      (ncyc),
    .err_i       (plan_err),
    .done_o      (done),
    .rdata_o     (rsp_rdata_o),
    .err_o       (rsp_err_o),
    .ce_no       (nand_ce_no),
    .cle_o       (nand_cle_o),
    .ale_o       (nand_ale_o),
    .we_no       (nand_we_no),
    .re_no       (nand_re_no),
    .dq_o        (nand_dq_o),
    .dq_oe_o     (nand_dq_oe_o),
    .dq_i        (nand_dq_i)
  );

  assign req_ready_o = done;
  assign rsp_valid_o = done;
endmodule

// File: rtl/nrs_checker.sv
module nrs_checker #(
  parameter int CS_N   = 8,
  parameter int ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic [ADDR_W-1:0] req_addr_i,
  input logic [1:0]        req_size_i,
  input logic              rsp_valid_o,
  input logic              rsp_err_o,
  input logic [CS_N-1:0]   nand_ce_no,
  input logic              nand_cle_o,
  input logic              nand_ale_o,
  input logic              nand_we_no,
  input logic              nand_re_no,
  input logic              nand_dq_oe_o
);
  a_r4_cle_ale_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(nand_cle_o && nand_ale_o));
  a_r4_qual_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |=> $stable(nand_cle_o) && $stable(nand_ale_o) && $stable(nand_ce_no));
  a_r9_strobe_one_clk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |=> (nand_we_no && nand_re_no));
  a_r9_we_re_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!nand_we_no && !nand_re_no));
  a_r9_oe_on_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nand_we_no |-> nand_dq_oe_o);
  a_r3_ce_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~nand_ce_no));
  a_r3_strobe_has_ce: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nand_we_no || !nand_re_no) |-> $countones(~nand_ce_no) == 1);
  a_r10_ready_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |=> !req_ready_o);
  a_r10_quiet_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> nand_we_no && nand_re_no && (&nand_ce_no) && !nand_cle_o && !nand_ale_o);
  // host assumption: request held until completion
  a_r10_host_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_ready_o) |=> req_valid_i && $stable(req_addr_i) && $stable(req_size_i));
  a_r8_err_nonword: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_err_o) |-> !req_size_i[1]);
endmodule

bind nand_reg_serializer nrs_checker #(.CS_N(CS_N), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .req_addr_i   (req_addr_i),
  .req_size_i   (req_size_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_err_o    (rsp_err_o),
  .nand_ce_no   (nand_ce_no),
  .nand_cle_o   (nand_cle_o),
  .nand_ale_o   (nand_ale_o),
  .nand_we_no   (nand_we_no),
  .nand_re_no   (nand_re_no),
  .nand_dq_oe_o (nand_dq_oe_o)
);

// File: tb/nand_reg_serializer_tb_top.sv
module nand_reg_serializer_tb_top;
  localparam int CS_N = 8;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_size = '0;
  logic [31:0]       req_wdata = '0;
  logic [CS_N*16-1:0] cs_cfg = '0;
  logic [15:0]       dq_in = '0;
  logic              req_ready, rsp_valid, rsp_err, cle, ale, we_n, re_n, dq_oe;
  logic [31:0]       rsp_rdata;
  logic [CS_N-1:0]   ce_n;
  logic [15:0]       dq_out;

  nand_reg_serializer #(.CS_N(CS_N), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_size_i(req_size), .req_wdata_i(req_wdata),
    .cs_cfg_i(cs_cfg), .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .rsp_err_o(rsp_err),
    .nand_ce_no(ce_n), .nand_cle_o(cle), .nand_ale_o(ale), .nand_we_no(we_n),
    .nand_re_no(re_n), .nand_dq_o(dq_out), .nand_dq_oe_o(dq_oe), .nand_dq_i(dq_in)
  );

  int n_chk = 0, n_err = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] pat(input int k);
    return 16'(16'hA050 + k * 16'h0113);
  endfunction

  // rk: 0 command, 1 address, 2 data, 3 other register
  typedef struct packed {
    logic wr; logic [1:0] sz; logic [2:0] cs; logic [1:0] rk;
    logic w16; logic nt; logic [2:0] n; logic err; logic [31:0] wd;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd2, 3'd0, 2'd0, 1'b0, 1'b1, 3'd4, 1'b0, 32'h11223344},
    '{1'b1, 2'd0, 3'd1, 2'd1, 1'b0, 1'b1, 3'd1, 1'b0, 32'h000000C5},
    '{1'b1, 2'd1, 3'd2, 2'd2, 1'b0, 1'b1, 3'd2, 1'b0, 32'h0000BEEF},
    '{1'b0, 2'd2, 3'd3, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0, 32'h0},
    '{1'b0, 2'd1, 3'd4, 2'd2, 1'b0, 1'b1, 3'd2, 1'b0, 32'h0},
    '{1'b1, 2'd1, 3'd5, 2'd0, 1'b1, 1'b1, 3'd1, 1'b0, 32'h00009A7B},
    '{1'b1, 2'd2, 3'd6, 2'd1, 1'b1, 1'b1, 3'd2, 1'b0, 32'hCAFE1234},
    '{1'b0, 2'd2, 3'd7, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0, 32'h0},
    '{1'b0, 2'd0, 3'd0, 2'd2, 1'b1, 1'b1, 3'd1, 1'b0, 32'h0},
    '{1'b1, 2'd0, 3'd1, 2'd2, 1'b1, 1'b1, 3'd1, 1'b0, 32'h00BEEF5A},
    '{1'b0, 2'd2, 3'd2, 2'd2, 1'b0, 1'b0, 3'd0, 1'b0, 32'h0},
    '{1'b1, 2'd2, 3'd3, 2'd0, 1'b0, 1'b0, 3'd0, 1'b0, 32'h12345678},
    '{1'b1, 2'd0, 3'd4, 2'd3, 1'b0, 1'b1, 3'd0, 1'b1, 32'h000000FF},
    '{1'b0, 2'd2, 3'd5, 2'd3, 1'b0, 1'b1, 3'd0, 1'b0, 32'h0},
    '{1'b0, 2'd1, 3'd6, 2'd0, 1'b0, 1'b1, 3'd0, 1'b0, 32'h0},
    '{1'b1, 2'd3, 3'd7, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0, 32'h89ABCDEF}
  };

  task automatic run_txn(input string tag, input vec_t v, input logic bit13);
    int lat, kw, kr;
    logic [15:0] wseen [4];
    logic ce_ok, qual_ok, oe_ok;
    logic [31:0] exp_rd;
    int off;
    @(negedge clk);
    for (int j = 0; j < CS_N; j++)
      cs_cfg[j*16 +: 16] = {2'b00, bit13, v.w16, (v.nt ? 2'd2 : 2'd0), 10'h000};
    off = (v.rk == 2'd0) ? 'h1C : (v.rk == 2'd1) ? 'h20 : (v.rk == 2'd2) ? 'h24 : 'h00;
    req_addr  = ADDR_W'('h60 + int'(v.cs) * 'h30 + off + (int'(v.cs) % 4));
    req_write = v.wr; req_size = v.sz; req_wdata = v.wd; req_valid = 1'b1;
    lat = 0; kw = 0; kr = 0; ce_ok = 1; qual_ok = 1; oe_ok = 1;
    for (int j = 0; j < 4; j++) wseen[j] = '0;
    do begin
      @(negedge clk);
      lat++;
      if (!we_n || !re_n) begin
        if (ce_n !== ~(CS_N'(1) << v.cs)) ce_ok = 0;
        if (cle !== (v.rk == 2'd0) || ale !== (v.rk == 2'd1)) qual_ok = 0;
      end
      if (!we_n) begin
        if (!dq_oe) oe_ok = 0;
        if (kw < 4) wseen[kw] = dq_out;
        kw++;
      end
      if (!re_n) begin
        dq_in = pat(kr);
        kr++;
      end
    end while (!req_ready && lat < 40);
    chk("R10", 32'(lat), 32'(2 * int'(v.n) + 1), {tag, " completion latency"});
    chk("R10", {31'b0, rsp_valid}, 32'd1, {tag, " rsp_valid with ready"});
    chk(tag, 32'(v.wr ? kw : kr), 32'(v.n), "strobe count");
    chk(tag, 32'(v.wr ? kr : kw), 32'd0, "opposite strobe count");
    chk("R8", {31'b0, rsp_err}, {31'b0, v.err}, {tag, " width error"});
    chk("R3", {31'b0, ce_ok}, 32'd1, {tag, " chip enable"});
    chk("R4", {31'b0, qual_ok}, 32'd1, {tag, " CLE/ALE qualifier"});
    chk("R9", {31'b0, oe_ok}, 32'd1, {tag, " output enable"});
    if (v.wr) begin
      for (int k = 0; k < int'(v.n) && k < 4; k++)
        chk(tag, {16'h0, wseen[k]},
            {16'h0, v.w16 ? v.wd[16*k +: 16] : {8'h00, v.wd[8*k +: 8]}}, "write cycle data");
    end else begin
      exp_rd = '0;
      for (int k = 0; k < int'(v.n); k++) begin
        if (!v.w16)            exp_rd[8*k +: 8] = pat(k)[7:0];
        else if (v.sz == 2'd0) exp_rd[7:0] = pat(k)[7:0];
        else                   exp_rd[16*k +: 16] = pat(k);
      end
      chk(tag, rsp_rdata, exp_rd, "read data");
    end
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic string tag_of(input vec_t v);
    if (!v.nt) return "R1";
    if (v.rk == 2'd3) return "R8";
    if (v.rk != 2'd2 && !v.wr) return "R1";
    if (v.w16 && v.sz == 2'd0) return "R7";
    if (v.w16) return "R6";
    return "R5";
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_err++;
      $display("FAIL R10 watchdog expired: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    vec_t dv;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11", {24'h0, ce_n}, {24'h0, {CS_N{1'b1}}}, "chip enables in reset");
    chk("R11", {29'h0, we_n, re_n, req_ready}, {29'h0, 3'b110}, "strobes/ready in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11", {29'h0, cle, ale, rsp_valid}, 32'h0, "CLE/ALE/rsp idle after reset");

    for (int i = 0; i < NV; i++) run_txn(tag_of(VEC[i]), VEC[i], 1'b0);

    // R2: bit 13 set must not change width
    dv = '{1'b1, 2'd2, 3'd1, 2'd2, 1'b0, 1'b1, 3'd4, 1'b0, 32'h5566AA77};
    run_txn("R2", dv, 1'b1);
    dv = '{1'b0, 2'd2, 3'd2, 2'd2, 1'b1, 1'b1, 3'd2, 1'b0, 32'h0};
    run_txn("R2", dv, 1'b1);
    // R8: size 3 is a word, no error on other register
    dv = '{1'b1, 2'd3, 3'd0, 2'd3, 1'b0, 1'b1, 3'd0, 1'b0, 32'h1};
    run_txn("R8", dv, 1'b0);
    // R11: idle after traffic
    chk("R11", {24'h0, ce_n}, {24'h0, {CS_N{1'b1}}}, "chip enables idle");

    done_flag = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule